// File: doc/BRIEF.md
# Intermediate Test Vector Inserter

This block sits between a pseudorandom vector source and a circuit under test. It turns a stream of n-bit random vectors into a stream with lower switching activity. For each pair of consecutive accepted vectors, it first emits three blended vectors and then the newer vector itself. The three blended vectors split the bit changes between the two vectors into four smaller steps, so fewer output bits toggle on each step. The vectors stay random, because the blends are built from the two random vectors and from a one-bit random input.

The input side is a valid/ready stream. The input is stalled while a group is being emitted, and one vector is accepted every four cycles in steady state. The output has no stall input. Each output vector is qualified by a valid flag and carries a 2-bit tag that says which kind of vector it is. The first vector after reset has nothing to blend with, so it is passed through on its own.

Top module: `lowtog_inserter`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The first vector accepted after reset appears one cycle later with out_tag 0 (original), and no intermediate vectors come before it.
- R3: When a vector is accepted and a predecessor exists, the next four output cycles carry out_tag 1, 2, 3 and then 0, in that order, each with out_valid high. Tag encoding: 0 = original, 1 = first blend, 2 = splice, 3 = last blend.
- R4: in_ready is 0 while tags 1, 2 and 3 are on the output, and it is 1 again when the original vector is on the output.
- R5: The tag-2 vector takes bits [N-1:N/2] from the predecessor and bits [N/2-1:0] from the new vector.
- R6: The tag-1 vector has, in each bit where the predecessor and the splice agree, their common value. In every other bit it has the value that rnd_bit had at the accepting clock edge.
- R7: The tag-3 vector has, in each bit where the splice and the new vector agree, their common value. In every other bit it has the value that rnd_bit had at the clock edge that loads the tag-3 vector, which is the edge at which the splice is on the output.
- R8: The bit toggles along predecessor → tag 1 → tag 2 → tag 3 → new vector add up to exactly the Hamming distance between the predecessor and the new vector.
- R9: The upper half of the tag-1 vector equals the predecessor, and the lower half of the tag-3 vector equals the new vector.
- R10: The tag-0 vector that closes a group equals the accepted vector, and that vector becomes the predecessor for the next group.
- R11: While the block is idle and in_valid is 0, out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector is offered |
| in_ready | output | 1 | Block can take an input vector |
| in_vec | input | N | Input random vector |
| rnd_bit | input | 1 | Random bit used to fill the bits that differ |
| out_valid | output | 1 | Output vector is valid |
| out_vec | output | N | Output vector |
| out_tag | output | 2 | Output vector kind (0 original, 1/2/3 intermediate) |

## Verification
The hardest case to reach is the exact timing of the random bit. The tag-1 vector must use rnd_bit at the accepting edge, and the tag-3 vector must use the value two edges later. A constant random input cannot tell these edges apart. The stimulus therefore drives a chosen value at each of the two sampling edges and the complement at every other edge, so reading the wrong edge shows up in the output. Directed groups cover the boundary cases: equal vectors (no bits differ), fully complemented vectors (every bit differs), and the change from all-zero to all-one. Random groups then cover mixed Hamming distances.

// File: rtl/lowtog_pkg.sv
// Shared types for the intermediate test vector inserter.
// Assumes: the tag values are seen at the output port and must not be changed.
package lowtog_pkg;
    typedef enum logic [1:0] {
        TAG_ORIG = 2'd0,
        TAG_K1   = 2'd1,
        TAG_K2   = 2'd2,
        TAG_K3   = 2'd3
    } vec_tag_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_K2   = 2'd1,
        ST_K3   = 2'd2,
        ST_ORIG = 2'd3
    } seq_state_e;
endpackage

// File: rtl/lowtog_splice.sv
// Half/half splice: the upper half comes from hi_src and the lower half from lo_src.
// Assumes: N is even.
module lowtog_splice #(
    parameter int N = 16
) (
    input  logic [N-1:0] hi_src,
    input  logic [N-1:0] lo_src,
    output logic [N-1:0] spliced
);
    localparam int HALF = N / 2;

    // Join the two halves.
    always_comb begin
        spliced = {hi_src[N-1:HALF], lo_src[HALF-1:0]};
    end
endmodule

// File: rtl/lowtog_inject.sv
// Bitwise random injection: a bit where a and b agree keeps that value;
// a bit where they differ takes rbit.
// Assumes: rbit is already sampled by the caller.
module lowtog_inject #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         rbit,
    output logic [N-1:0] y
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            // One AND/OR/select cell per bit position.
            logic both_one, any_one;
            assign both_one = a[gi] & b[gi];
            assign any_one  = a[gi] | b[gi];
            assign y[gi]    = rbit ? any_one : both_one;
        end
    endgenerate
endmodule

// File: rtl/lowtog_seq.sv
// Group sequencer: steps IDLE -> K2 -> K3 -> ORIG after a vector is accepted
// that has a predecessor. It also remembers whether any vector has been taken.
// Assumes: accept is only high while in_ready is high.
module lowtog_seq
    import lowtog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    output logic       in_ready,
    output logic       have_prev,
    output seq_state_e state
);
    seq_state_e state_nx;

    // Next-state choice for the four-cycle group.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && have_prev) state_nx = ST_K2;
            ST_K2:   state_nx = ST_K3;
            ST_K3:   state_nx = ST_ORIG;
            ST_ORIG: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and the predecessor-present flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            have_prev <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) have_prev <= 1'b1;
        end
    end

    assign in_ready = (state == ST_IDLE);
endmodule

// File: rtl/lowtog_inserter.sv
// Top: inserts three low-toggle vectors between consecutive input vectors.
// Output order for each pair: K1, K2, K3, then the new original vector.
// Assumes: N is even; the output side has no stall; rnd_bit is a random source.
module lowtog_inserter
    import lowtog_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [N-1:0] in_vec,
    input  logic         rnd_bit,
    output logic         out_valid,
    output logic [N-1:0] out_vec,
    output logic [1:0]   out_tag
);
    logic [N-1:0] prev_q, cur_q;
    logic [N-1:0] spl_new, spl_cur, k1_new, k3_cur;
    logic         accept, have_prev;
    seq_state_e   state;
    vec_tag_e     tag_q;

    assign accept = in_valid && in_ready;

    lowtog_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_ready  (in_ready),
        .have_prev (have_prev),
        .state     (state)
    );

    // Splice of predecessor and the vector being accepted (feeds K1).
    lowtog_splice #(.N(N)) u_spl_new (.hi_src(prev_q), .lo_src(in_vec), .spliced(spl_new));
    // Splice of predecessor and the stored new vector (K2 itself, feeds K3).
    lowtog_splice #(.N(N)) u_spl_cur (.hi_src(prev_q), .lo_src(cur_q),  .spliced(spl_cur));
    // K1: between the predecessor and the splice.
    lowtog_inject #(.N(N)) u_inj_k1 (.a(prev_q),  .b(spl_new), .rbit(rnd_bit), .y(k1_new));
    // K3: between the splice and the new vector.
    lowtog_inject #(.N(N)) u_inj_k3 (.a(spl_cur), .b(cur_q),   .rbit(rnd_bit), .y(k3_cur));

    // Output register and vector storage, steered by the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            tag_q     <= TAG_ORIG;
            prev_q    <= '0;
            cur_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    out_valid <= accept;
                    if (accept && have_prev) begin
                        out_vec <= k1_new;
                        tag_q   <= TAG_K1;
                        cur_q   <= in_vec;
                    end else if (accept) begin
                        out_vec <= in_vec;
                        tag_q   <= TAG_ORIG;
                        prev_q  <= in_vec;
                    end
                end
                ST_K2: begin
                    out_valid <= 1'b1;
                    out_vec   <= spl_cur;
                    tag_q     <= TAG_K2;
                end
                ST_K3: begin
                    out_valid <= 1'b1;
                    out_vec   <= k3_cur;
                    tag_q     <= TAG_K3;
                end
                ST_ORIG: begin
                    out_valid <= 1'b1;
                    out_vec   <= cur_q;
                    tag_q     <= TAG_ORIG;
                    prev_q    <= cur_q;
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end

    assign out_tag = tag_q;
endmodule

// File: rtl/lowtog_checker.sv
// Checker for lowtog_inserter; it sees only the ports and keeps its own copies
// of the predecessor, the accepted vector and the blends it has observed.
module lowtog_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [N-1:0] in_vec,
    input logic         rnd_bit,
    input logic         out_valid,
    input logic [N-1:0] out_vec,
    input logic [1:0]   out_tag
);
    localparam int HALF = N / 2;

    logic         seen, acc;
    logic [N-1:0] last_orig, pend, s_k1, s_k2, s_k3;
    int           tog_sum, tog_ref;

    function automatic logic [N-1:0] f_splice(input logic [N-1:0] h, input logic [N-1:0] l);
        return {h[N-1:HALF], l[HALF-1:0]};
    endfunction

    function automatic logic [N-1:0] f_inject(input logic [N-1:0] a, input logic [N-1:0] b,
                                              input logic r);
        return (a & b) | ((a ^ b) & {N{r}});
    endfunction

    assign acc = in_valid && in_ready;

    // Observed history taken from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0; last_orig <= '0; pend <= '0;
            s_k1 <= '0; s_k2 <= '0; s_k3 <= '0;
        end else begin
            if (acc) begin seen <= 1'b1; pend <= in_vec; end
            if (out_valid && out_tag == 2'd0) last_orig <= out_vec;
            if (out_valid && out_tag == 2'd1) s_k1 <= out_vec;
            if (out_valid && out_tag == 2'd2) s_k2 <= out_vec;
            if (out_valid && out_tag == 2'd3) s_k3 <= out_vec;
        end
    end

    always_comb begin
        tog_sum = $countones(last_orig ^ s_k1) + $countones(s_k1 ^ s_k2)
                + $countones(s_k2 ^ s_k3) + $countones(s_k3 ^ out_vec);
        tog_ref = $countones(last_orig ^ out_vec);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && in_ready));
    p_first_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !seen) |=> (out_valid && out_tag == 2'd0 && out_vec == $past(in_vec)));
    p_start_k1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen) |=> (out_valid && out_tag == 2'd1));
    p_k1_to_k2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd1) |=> (out_valid && out_tag == 2'd2));
    p_k2_to_k3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd2) |=> (out_valid && out_tag == 2'd3));
    p_k3_to_orig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd3) |=> (out_valid && out_tag == 2'd0));
    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag != 2'd0) |-> !in_ready);
    p_splice_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd2) |-> (out_vec == f_splice(last_orig, pend)));
    p_k1_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd1) |->
        (out_vec == f_inject(last_orig, f_splice(last_orig, pend), $past(rnd_bit))));
    p_k3_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd3) |->
        (out_vec == f_inject(f_splice(last_orig, pend), pend, $past(rnd_bit))));
    p_toggle_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd0 && $past(out_valid) && $past(out_tag) == 2'd3)
        |-> (tog_sum == tog_ref));
    p_halves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd3) |->
        (out_vec[HALF-1:0] == pend[HALF-1:0] && s_k1[N-1:HALF] == last_orig[N-1:HALF]));
    p_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag == 2'd0 && $past(out_valid) && $past(out_tag) == 2'd3)
        |-> (out_vec == pend && in_ready));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid);
endmodule

bind lowtog_inserter lowtog_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_vec    (in_vec),
    .rnd_bit   (rnd_bit),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_tag   (out_tag)
);

// File: tb/sim_lowtog_inserter.sv
`timescale 1ns/1ps
module sim_lowtog_inserter;
    localparam int N    = 16;
    localparam int HALF = N / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_vec = '0;
    logic         rnd_bit = 1'b0;
    logic         out_valid;
    logic [N-1:0] out_vec;
    logic [1:0]   out_tag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [N-1:0] prev_v;
    bit           have_prev = 1'b0;

    always #4 clk = ~clk;

    lowtog_inserter #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .rnd_bit(rnd_bit), .out_valid(out_valid),
        .out_vec(out_vec), .out_tag(out_tag)
    );

    function automatic logic [N-1:0] exp_splice(input logic [N-1:0] h, input logic [N-1:0] l);
        logic [N-1:0] y;
        for (int i = 0; i < N; i++) y[i] = (i >= HALF) ? h[i] : l[i];
        return y;
    endfunction

    function automatic logic [N-1:0] exp_inject(input logic [N-1:0] a, input logic [N-1:0] b,
                                                input logic r);
        logic [N-1:0] y;
        for (int i = 0; i < N; i++) y[i] = (a[i] == b[i]) ? a[i] : r;
        return y;
    endfunction

    function automatic int hd(input logic [N-1:0] a, input logic [N-1:0] b);
        int c = 0;
        for (int i = 0; i < N; i++) if (a[i] != b[i]) c++;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    // Offer one vector and check everything that follows until the block is ready again.
    task automatic send(input logic [N-1:0] v, input logic r1, input logic r3);
        logic [N-1:0] e1, e2, e3, o1, o2, o3;
        @(negedge clk);
        in_valid = 1'b1; in_vec = v; rnd_bit = r1;
        chk(in_ready == 1'b1, "R4 ready before offer", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0; rnd_bit = ~r1;
        if (!have_prev) begin
            chk(out_valid && out_tag == 2'd0 && out_vec == v, "R2 first alone",
                {14'd0, out_tag, out_vec}, {16'd0, v});
            prev_v = v; have_prev = 1'b1;
            return;
        end
        e2 = exp_splice(prev_v, v);
        e1 = exp_inject(prev_v, e2, r1);
        e3 = exp_inject(e2, v, r3);
        chk(out_valid && out_tag == 2'd1, "R3 tag k1", {30'd0, out_tag}, 32'd1);
        chk(out_vec == e1, "R6 k1 value", {16'd0, out_vec}, {16'd0, e1});
        chk(in_ready == 1'b0, "R4 stall during k1", {31'd0, in_ready}, 32'd0);
        o1 = out_vec;
        rnd_bit = ~r3;
        @(negedge clk);
        chk(out_valid && out_tag == 2'd2, "R3 tag k2", {30'd0, out_tag}, 32'd2);
        chk(out_vec == e2, "R5 splice", {16'd0, out_vec}, {16'd0, e2});
        o2 = out_vec;
        rnd_bit = r3;
        @(negedge clk);
        chk(out_valid && out_tag == 2'd3, "R3 tag k3", {30'd0, out_tag}, 32'd3);
        chk(out_vec == e3, "R7 k3 value", {16'd0, out_vec}, {16'd0, e3});
        chk(in_ready == 1'b0, "R4 stall during k3", {31'd0, in_ready}, 32'd0);
        o3 = out_vec;
        chk(o1[N-1:HALF] == prev_v[N-1:HALF] && o3[HALF-1:0] == v[HALF-1:0], "R9 halves",
            {16'd0, o1[N-1:HALF], o3[HALF-1:0]}, {16'd0, prev_v[N-1:HALF], v[HALF-1:0]});
        rnd_bit = ~r3;
        @(negedge clk);
        chk(out_valid && out_tag == 2'd0 && out_vec == v, "R10 closing original",
            {14'd0, out_tag, out_vec}, {16'd0, v});
        chk(in_ready == 1'b1, "R4 ready at original", {31'd0, in_ready}, 32'd1);
        chk(hd(prev_v, o1) + hd(o1, o2) + hd(o2, o3) + hd(o3, out_vec) == hd(prev_v, v),
            "R8 toggle sum", hd(prev_v, o1) + hd(o1, o2) + hd(o2, o3) + hd(o3, out_vec),
            hd(prev_v, v));
        prev_v = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset state",
            {30'd0, out_valid, in_ready}, 32'd1);
        // R11: idle with no offer
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R11 idle quiet", {31'd0, out_valid}, 32'd0);
        end
        send(16'hA5C3, 1'b0, 1'b1);           // R2 first vector
        send(16'hA5C3, 1'b1, 1'b0);           // equal vectors, distance 0
        send(16'h5A3C, 1'b0, 1'b1);           // complement, every bit differs
        send(16'h0000, 1'b1, 1'b1);
        send(16'hFFFF, 1'b0, 1'b0);           // all-zero to all-one
        send(16'hFFFF, 1'b1, 1'b0);
        // R11 again after a group
        repeat (2) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R11 idle after group", {31'd0, out_valid}, 32'd0);
        end
        for (int g = 0; g < 40; g++) begin
            send(N'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule